// File: doc/BRIEF.md
# Indirect Peripheral Register Access Bridge

This bridge gives a CPU access to a 32-entry internal peripheral register space. The CPU sees only two 8-bit locations. The control location holds a direction bit, a read-only busy flag, a reserved bit and a 5-bit offset. The data location carries the value being moved. The bridge turns accesses to these two locations into single transactions on an internal request/acknowledge bus.

A read is launched by writing the control location with the direction bit set. When the internal side acknowledges, the returned value lands in the data location. The CPU fetches it there once busy has dropped.

A write takes two steps. The CPU first programs the control location with the direction bit clear, which only selects the offset. It then loads the data location, and that load launches the transaction. The internal side may hold off the acknowledge for any number of cycles.

While a transfer is running, the bridge ignores CPU writes to either location. Offset 00h, offset 0Fh and offsets 15h–1Fh are treated as no-operation targets. The live registers are control, status and byte-count registers at 01h–0Eh and five buffer ports at 10h–14h.

The internal bus is a plain one-cycle request plus acknowledge, not valid/ready. The bridge never has more than one transaction open, so back-pressure is expressed only as acknowledge latency. The CPU sees that latency through the busy flag.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the control readback is 00h, the data readback is 00h and no request is raised.
- R2: Control readback layout: bit 7 is the direction (1 = read, 0 = write), bit 6 is busy, bit 5 always reads 0 whatever was written to it, and bits 4:0 are the offset.
- R3: A control write with direction 1 to a live offset raises `req` in the next cycle, with `req_addr` equal to the offset and `req_we` = 0. Busy reads 1 in that same cycle.
- R4: A control write with direction 0 raises no request. The next data-location load launches a request in the following cycle with `req_we` = 1, `req_addr` equal to the programmed offset and `req_wdata` equal to the loaded value.
- R5: `req` lasts exactly one cycle. Busy stays 1 until `ack` is sampled and reads 0 in the cycle after `ack`. An `ack` may come in the same cycle as `req`.
- R6: When a read completes, the `rdata` present with `ack` is stored in the data location.
- R7: A control write while busy is 1 changes no field of the control location.
- R8: A data-location load while busy is 1 changes neither the data location nor the transfer in flight.
- R9: A transfer to offset 00h, 0Fh or 15h–1Fh raises no request. Busy is 1 for exactly one cycle, and a read leaves the data location unchanged.
- R10: A data-location load while idle with direction 1 updates the data location and launches no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per access |
| cpu_sel | input | 1 | Location select: 0 = control, 1 = data |
| cpu_wdata | input | 8 | CPU write value |
| cpu_ctrl_q | output | 8 | Control location readback |
| cpu_data_q | output | 8 | Data location readback |
| req | output | 1 | One-cycle internal request |
| req_addr | output | 5 | Internal register offset |
| req_we | output | 1 | 1 = internal write, 0 = internal read |
| req_wdata | output | 8 | Internal write value |
| ack | input | 1 | Internal completion |
| rdata | input | 8 | Internal read value, valid with ack |

## Verification
The bench builds the bridge at its default widths: a 5-bit offset and 8-bit data. At these widths the whole 32-entry offset space is reachable, including both no-operation ranges and the boundaries 0Eh/0Fh/10h and 14h/15h. The acknowledge latency is drawn from 0 to 5 cycles, so same-cycle acknowledges are covered. Intruding CPU writes land inside the busy window to exercise the lockout.

// File: rtl/irb_pkg.sv
package irb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_NOOP = 2'd2
  } irb_state_t;
endpackage

// File: rtl/irb_ctrl_reg.sv
module irb_ctrl_reg #(
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             busy,
  input  logic             wr_dir,
  input  logic [OFF_W-1:0] wr_off,
  output logic             dir,
  output logic [OFF_W-1:0] off
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir <= 1'b0;
      off <= '0;
    end else if (wr && !busy) begin
      dir <= wr_dir;
      off <= wr_off;
    end
  end

  // R7
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy) |=> ($stable(dir) && $stable(off)));
endmodule

// File: rtl/irb_seq.sv
module irb_seq
  import irb_pkg::*;
#(
  parameter int OFF_W   = 5,
  parameter int LIVE_HI = 20,
  parameter int HOLE    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic [OFF_W-1:0] start_off,
  input  logic             ack,
  output logic             busy,
  output logic             req,
  output logic [OFF_W-1:0] req_addr,
  output logic             req_we,
  output logic             cap
);
  irb_state_t st;

  function automatic logic is_noop(input logic [OFF_W-1:0] a);
    return (a == '0) || (int'(a) == HOLE) || (int'(a) > LIVE_HI);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      req      <= 1'b0;
      req_addr <= '0;
      req_we   <= 1'b0;
    end else begin
      req <= 1'b0;
      case (st)
        ST_IDLE: if (start_rd || start_wr) begin
          req_addr <= start_off;
          req_we   <= start_wr;
          if (is_noop(start_off)) st <= ST_NOOP;
          else begin
            st  <= ST_WAIT;
            req <= 1'b1;
          end
        end
        ST_WAIT: if (ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);
  assign cap  = (st == ST_WAIT) && ack && !req_we;

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy);
  // R9
  noop_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !is_noop(req_addr));
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req && ack && st == ST_WAIT) |=> !busy);
  // R9
  noop_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NOOP) |=> !busy);
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int OFF_W   = 5,
  parameter int DAT_W   = 8,
  parameter int LIVE_HI = 20,
  parameter int HOLE    = 15,
  localparam int CTRL_W = OFF_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic              cpu_sel,
  input  logic [DAT_W-1:0]  cpu_wdata,
  output logic [CTRL_W-1:0] cpu_ctrl_q,
  output logic [DAT_W-1:0]  cpu_data_q,
  output logic              req,
  output logic [OFF_W-1:0]  req_addr,
  output logic              req_we,
  output logic [DAT_W-1:0]  req_wdata,
  input  logic              ack,
  input  logic [DAT_W-1:0]  rdata
);
  logic             dir, busy, cap;
  logic [OFF_W-1:0] off;
  logic             ctrl_wr, data_wr, start_rd, start_wr;
  logic [OFF_W-1:0] start_off;
  logic [DAT_W-1:0] data_q;

  assign ctrl_wr   = cpu_we && !cpu_sel;
  assign data_wr   = cpu_we && cpu_sel && !busy;
  assign start_rd  = ctrl_wr && !busy && cpu_wdata[CTRL_W-1];
  assign start_wr  = data_wr && !dir;
  assign start_off = start_rd ? cpu_wdata[OFF_W-1:0] : off;

  irb_ctrl_reg #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .busy(busy),
    .wr_dir(cpu_wdata[CTRL_W-1]), .wr_off(cpu_wdata[OFF_W-1:0]),
    .dir(dir), .off(off)
  );

  irb_seq #(.OFF_W(OFF_W), .LIVE_HI(LIVE_HI), .HOLE(HOLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
    .start_off(start_off), .ack(ack), .busy(busy), .req(req),
    .req_addr(req_addr), .req_we(req_we), .cap(cap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       data_q <= '0;
    else if (cap)     data_q <= rdata;
    else if (data_wr) data_q <= cpu_wdata;
  end

  assign cpu_data_q = data_q;
  assign req_wdata  = data_q;
  assign cpu_ctrl_q = {dir, busy, 1'b0, off};

  // R8
  data_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_we && cpu_sel && !cap) |=> $stable(cpu_data_q));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ctrl_q[CTRL_W-3] == 1'b0);
endmodule

// File: tb/tb_ind_reg_bridge.sv
`timescale 1ns/1ps
module tb_ind_reg_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_ctrl_q, cpu_data_q;
  logic       req, req_we;
  logic [4:0] req_addr;
  logic [7:0] req_wdata;
  logic       ack = 1'b0;
  logic [7:0] rdata = '0;

  int checks = 0, errors = 0;
  logic [7:0] mem [32];
  logic       exp_dir = 1'b0;
  logic [4:0] exp_off = '0;
  logic [7:0] exp_data = '0;

  ind_reg_bridge dut (.*);

  always #2.5 clk = ~clk;

  function automatic bit is_noop(input logic [4:0] a);
    return (a == 5'h00) || (a == 5'h0F) || (a >= 5'h15);
  endfunction

  function automatic logic [7:0] exp_ctrl(input logic b);
    return {exp_dir, b, 1'b0, exp_off};
  endfunction

  task automatic check(input bit ok, input string r, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  task automatic cpu_write(input logic sel, input logic [7:0] v);
    cpu_sel = sel; cpu_wdata = v; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  // At the req cycle: wait dly cycles, optionally intrude, then ack
  task automatic finish_xfer(input int dly, input bit intrude, input bit rd, input logic [4:0] a);
    for (int i = 0; i < dly; i++) begin
      if (intrude && i == 0) begin
        cpu_sel = $urandom; cpu_wdata = $urandom; cpu_we = 1'b1;
      end
      @(negedge clk);
      cpu_we = 1'b0;
      check(cpu_ctrl_q[6] == 1'b1, "R5 busy held", cpu_ctrl_q[6], 1);
      check(req == 1'b0, "R5 req one cycle", req, 0);
      check(cpu_ctrl_q == exp_ctrl(1'b1), "R7 ctrl locked", cpu_ctrl_q, exp_ctrl(1'b1));
      check(cpu_data_q == exp_data, "R8 data locked", cpu_data_q, exp_data);
    end
    rdata = rd ? mem[a] : 8'($urandom);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    if (rd) exp_data = mem[a];
    check(cpu_ctrl_q[6] == 1'b0, "R5 busy clears after ack", cpu_ctrl_q[6], 0);
    check(cpu_data_q == exp_data, rd ? "R6 read capture" : "R8 write data", cpu_data_q, exp_data);
  endtask

  task automatic do_read(input logic [4:0] a, input bit rsv, input int dly, input bit intrude);
    cpu_write(1'b0, {1'b1, 1'b0, rsv, a});
    exp_dir = 1'b1; exp_off = a;
    check(cpu_ctrl_q == exp_ctrl(1'b1), "R2 ctrl readback", cpu_ctrl_q, exp_ctrl(1'b1));
    if (is_noop(a)) begin
      check(req == 1'b0, "R9 no req", req, 0);
      @(negedge clk);
      check(cpu_ctrl_q[6] == 1'b0, "R9 busy one cycle", cpu_ctrl_q[6], 0);
      check(cpu_data_q == exp_data, "R9 data kept", cpu_data_q, exp_data);
    end else begin
      check(req && !req_we && req_addr == a, "R3 read req", {req, req_we, req_addr}, {2'b10, a});
      finish_xfer(dly, intrude, 1'b1, a);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] v, input int dly, input bit intrude);
    cpu_write(1'b0, {1'b0, 1'b1, 1'b1, a});
    exp_dir = 1'b0; exp_off = a;
    check(!req && cpu_ctrl_q == exp_ctrl(1'b0), "R4 no req on ctrl", cpu_ctrl_q, exp_ctrl(1'b0));
    cpu_write(1'b1, v);
    exp_data = v;
    if (is_noop(a)) begin
      check(req == 1'b0 && cpu_ctrl_q[6], "R9 noop write", {req, cpu_ctrl_q[6]}, 1);
      @(negedge clk);
      check(cpu_ctrl_q[6] == 1'b0, "R9 busy one cycle", cpu_ctrl_q[6], 0);
    end else begin
      check(req && req_we && req_addr == a && req_wdata == v, "R4 write req",
            {req, req_we, req_addr, req_wdata}, {2'b11, a, v});
      mem[a] = v;
      finish_xfer(dly, intrude, 1'b0, a);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ctrl_q == 8'h00 && cpu_data_q == 8'h00 && !req, "R1 reset",
          {cpu_ctrl_q, cpu_data_q}, 0);
    // R2 reserved bit write, read of live offset
    do_read(5'h01, 1'b1, 0, 1'b0);
    // R9 boundaries
    do_read(5'h00, 1'b0, 1, 1'b0);
    do_read(5'h0F, 1'b1, 1, 1'b0);
    do_read(5'h15, 1'b0, 1, 1'b0);
    do_read(5'h1F, 1'b0, 1, 1'b0);
    do_read(5'h0E, 1'b0, 2, 1'b1);
    do_read(5'h10, 1'b0, 3, 1'b1);
    do_read(5'h14, 1'b0, 4, 1'b1);
    do_write(5'h0F, 8'hA5, 1, 1'b0);
    do_write(5'h14, 8'h3C, 0, 1'b0);
    do_write(5'h02, 8'h96, 5, 1'b1);
    do_read(5'h02, 1'b0, 1, 1'b0);
    check(cpu_data_q == 8'h96, "R4 write landed", cpu_data_q, 8'h96);
    // R10 data load with direction 1 while idle
    do_read(5'h03, 1'b0, 1, 1'b0);
    cpu_write(1'b1, 8'h5A);
    exp_data = 8'h5A;
    check(!req && !cpu_ctrl_q[6] && cpu_data_q == 8'h5A, "R10 load no xfer",
          {req, cpu_ctrl_q[6], cpu_data_q}, 8'h5A);
    @(negedge clk);
    check(!req && !cpu_ctrl_q[6], "R10 still idle", {req, cpu_ctrl_q[6]}, 0);
    for (int n = 0; n < 300; n++) begin
      logic [4:0] a;
      a = 5'($urandom);
      if ($urandom_range(1, 0) == 1)
        do_read(a, 1'($urandom), $urandom_range(5, 0), 1'($urandom));
      else
        do_write(a, 8'($urandom), $urandom_range(5, 0), 1'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule